// File: doc/BRIEF.md
# Display Adapter Host Register Decoder

This block is the host-facing register front end of a 16-color display adapter. It decodes 8-bit I/O reads and writes in the 0x3B0 to 0x3DF window and keeps several kinds of register:

- a control byte;
- three indexed register files (CRT controller, sequencer and graphics controller);
- a write-protected extended-mode byte;
- a palette-extension byte.

It also assembles the monochrome and color status bytes from live display-enable, vsync and light-pen inputs.

Bit 0 of the control byte moves the CRT controller, protection, status and extended-mode ports between the 0x3Bx bank and the 0x3Dx bank. Bit 1 of the control byte drives the video-RAM enable. The extended-mode byte accepts a write only after the protection port has been read at least twice.

The bus is synchronous. On a single-cycle strobe (`rd` or `wr`), the block acts on the address in that cycle. Read data is registered. Raster timing, pixel fetch, the palette DAC and the video memory itself sit outside this block.

Top module: `egaio_regs`

## Requirements
- R1: After reset, every register, every file entry and the protection counter are zero. As a result `color_sel`, `vram_en`, `ext_mode`, `pal_mode` and `rdata` are all 0.
- R2: A write at 0x3C2 loads the control byte. From the next cycle, bit 1 drives `vram_en`, and bit 0 drives `color_sel` (1 selects the 0x3Dx bank, 0 selects the 0x3Bx bank).
- R3: `rdata` carries the value of a read in the cycle after `rd` is high. It is 0x00 after any cycle without `rd`.
- R4: The CRT controller file has 32 entries. Its index is written at offset 4 of the active bank, and bits [4:0] of that index select the entry. Data is written and read back at offset 5 of the active bank. Both banks reach the same file.
- R5: The sequencer index is written at 0x3C4. Index bits [2:0] select one of 8 entries, which is written and read at 0x3C5.
- R6: The graphics-controller index is written at 0x3CE. Index bits [3:0] select one of 16 entries, which is written and read at 0x3CF.
- R7: Each read of offset 8 of the active bank increments the protection counter, which stops at 3. A read of offset 8 in the inactive bank does not count.
- R8: A write at offset 0xB of the active bank loads `ext_mode` only when the counter is 2 or more. That write returns the counter to 0. A write while the counter is 0 or 1 leaves `ext_mode` unchanged.
- R9: In mono mode, a read at 0x3BA returns bit 0 = display enable, bit 1 = light-pen strobe, bit 2 = 1, bit 7 = inverted vsync, and zeros in bits 3 to 6.
- R10: In color mode, a read at 0x3DA returns bit 0 = display enable, bit 1 = light-pen strobe, bit 2 = 1, bit 3 = inverted vsync, bit 7 = 1, and zeros in bits 4 to 6.
- R11: A write at 0x3DD loads `pal_mode` in either bank mode. Bits 5 and 4 enable the two extended palettes, and bit 6 selects the plane position.
- R12: A port of the inactive bank, or any unmapped address, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 10 | I/O address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| rdata | output | 8 | Registered read data |
| de_in | input | 1 | Display enable from the timing block |
| vsync_in | input | 1 | Vertical sync, active high |
| lpen_in | input | 1 | Light-pen strobe |
| color_sel | output | 1 | 1 when the 0x3Dx bank is active |
| vram_en | output | 1 | Video-RAM access enable |
| ext_mode | output | 8 | Extended-mode byte |
| pal_mode | output | 8 | Palette-extension byte |

## Verification
Every write takes effect at the clock edge of its strobe. Its effect is therefore visible on `color_sel`, `vram_en`, `ext_mode`, `pal_mode`, or on a following read, from the next cycle on.

A read's value appears on `rdata` one edge after the strobe and is cleared again one edge later. The bench raises each strobe at a falling edge and drops it at the next falling edge. It samples `rdata` at that second falling edge, which is exactly one rising edge after the strobe.

The status inputs are changed only between reads, so the byte captured with the strobe is known when the check is made.

// File: rtl/egaio_pkg.sv
package egaio_pkg;
   localparam int unsigned DW = 8;
   localparam int unsigned AW = 10;

   // upper address nibbles of the three banks
   localparam logic [5:0] HI_MONO   = 6'h3B;
   localparam logic [5:0] HI_COLOR  = 6'h3D;
   localparam logic [5:0] HI_SHARED = 6'h3C;

   // offsets inside the switched bank (position decoded by software)
   localparam logic [3:0] SW_CRTC_IDX = 4'h4;
   localparam logic [3:0] SW_CRTC_DAT = 4'h5;
   localparam logic [3:0] SW_UNLOCK   = 4'h8;
   localparam logic [3:0] SW_STATUS   = 4'hA;
   localparam logic [3:0] SW_EXTMODE  = 4'hB;

   // offsets inside the shared bank
   localparam logic [3:0] SH_CTRL    = 4'h2;
   localparam logic [3:0] SH_SEQ_IDX = 4'h4;
   localparam logic [3:0] SH_SEQ_DAT = 4'h5;
   localparam logic [3:0] SH_GC_IDX  = 4'hE;
   localparam logic [3:0] SH_GC_DAT  = 4'hF;

   localparam logic [AW-1:0] PALEXT_ADDR = 10'h3DD;

   typedef enum logic {LAYOUT_MONO = 1'b0, LAYOUT_COLOR = 1'b1} status_layout_e;

   typedef struct packed {
      logic crtc_idx;
      logic crtc_dat;
      logic unlock;
      logic status;
      logic extmode;
      logic ctrl;
      logic seq_idx;
      logic seq_dat;
      logic gc_idx;
      logic gc_dat;
      logic palext;
   } port_hit_t;
endpackage

// File: rtl/egaio_decode.sv
module egaio_decode
   import egaio_pkg::*;
(
   input  logic [AW-1:0] addr,
   input  logic          color,
   output port_hit_t     hit
);
   logic [5:0] hi;
   logic [3:0] lo;
   logic       in_bank;
   logic       in_shared;

   assign hi        = addr[AW-1:4];
   assign lo        = addr[3:0];
   assign in_bank   = (hi == (color ? HI_COLOR : HI_MONO));
   assign in_shared = (hi == HI_SHARED);

   always_comb begin
      hit          = '0;
      hit.crtc_idx = in_bank && (lo == SW_CRTC_IDX);
      hit.crtc_dat = in_bank && (lo == SW_CRTC_DAT);
      hit.unlock   = in_bank && (lo == SW_UNLOCK);
      hit.status   = in_bank && (lo == SW_STATUS);
      hit.extmode  = in_bank && (lo == SW_EXTMODE);
      hit.ctrl     = in_shared && (lo == SH_CTRL);
      hit.seq_idx  = in_shared && (lo == SH_SEQ_IDX);
      hit.seq_dat  = in_shared && (lo == SH_SEQ_DAT);
      hit.gc_idx   = in_shared && (lo == SH_GC_IDX);
      hit.gc_dat   = in_shared && (lo == SH_GC_DAT);
      hit.palext   = (addr == PALEXT_ADDR);
   end
endmodule

// File: rtl/egaio_idx_file.sv
module egaio_idx_file #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_we,
   input  logic             dat_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rd_data
);
   localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << IW) != DEPTH || IW > WIDTH) begin : g_bad_depth
      $error("egaio_idx_file: DEPTH must be a power of two between 2 and 2**WIDTH");
   end

   logic [IW-1:0]    idx_q;
   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (idx_we) idx_q <= wdata[IW-1:0];
         if (dat_we) mem_q[idx_q] <= wdata;
      end
   end

   assign rd_data = mem_q[idx_q];

   AST_FILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_we && !dat_we) |=> $stable(rd_data)); // R4 R5 R6
   AST_FILE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && !idx_we) |=> (rd_data == $past(wdata))); // R4 R5 R6
endmodule

// File: rtl/egaio_unlock.sv
module egaio_unlock #(
   parameter int unsigned CW     = 2,
   parameter int unsigned THRESH = 1,
   parameter int unsigned WIDTH  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             probe,
   input  logic             ext_wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] ext_q
);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
   localparam logic [CW-1:0] CNT_THR = CW'(THRESH);

   if (((1 << CW) - 1) <= THRESH) begin : g_bad_cw
      $error("egaio_unlock: counter too narrow to pass THRESH");
   end

   logic [CW-1:0] cnt_q;
   logic          open;

   assign open = (cnt_q > CNT_THR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ext_q <= '0;
      end else if (ext_wr && open) begin
         cnt_q <= '0;
         ext_q <= wdata;
      end else if (probe && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && !open) |=> $stable(ext_q)); // R8
   AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && open) |=> (cnt_q == '0 && ext_q == $past(wdata))); // R8
   AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !ext_wr) |=> (cnt_q == CNT_MAX)); // R7
   AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!probe && !ext_wr) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/egaio_status.sv
module egaio_status
   import egaio_pkg::*;
#(
   parameter status_layout_e LAYOUT = LAYOUT_MONO
) (
   input  logic          de,
   input  logic          lpen,
   input  logic          vsync,
   output logic [DW-1:0] stat
);
   if (LAYOUT == LAYOUT_COLOR) begin : g_color
      assign stat = {1'b1, 3'b000, ~vsync, 1'b1, lpen, de};
   end else begin : g_mono
      assign stat = {~vsync, 3'b000, 1'b0, 1'b1, lpen, de};
   end
endmodule

// File: rtl/egaio_regs.sv
module egaio_regs
   import egaio_pkg::*;
#(
   parameter int unsigned CRTC_DEPTH = 32,
   parameter int unsigned SEQ_DEPTH  = 8,
   parameter int unsigned GC_DEPTH   = 16,
   parameter int unsigned UNLOCK_CW  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [9:0]    addr,
   input  logic [7:0]    wdata,
   input  logic          rd,
   input  logic          wr,
   output logic [7:0]    rdata,
   input  logic          de_in,
   input  logic          vsync_in,
   input  logic          lpen_in,
   output logic          color_sel,
   output logic          vram_en,
   output logic [7:0]    ext_mode,
   output logic [7:0]    pal_mode
);
   localparam int unsigned UNLOCK_THRESH = 1;

   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] pal_q;
   logic [DW-1:0] rd_mux;
   logic [DW-1:0] crtc_rd, seq_rd, gc_rd;
   logic [DW-1:0] stat_mono, stat_color;
   port_hit_t     hit;

   assign color_sel = ctrl_q[0];
   assign vram_en   = ctrl_q[1];
   assign pal_mode  = pal_q;

   egaio_decode u_dec (
      .addr  (addr),
      .color (ctrl_q[0]),
      .hit   (hit)
   );

   egaio_idx_file #(.DEPTH(CRTC_DEPTH), .WIDTH(DW)) u_crtc (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_we  (wr && hit.crtc_idx),
      .dat_we  (wr && hit.crtc_dat),
      .wdata   (wdata),
      .rd_data (crtc_rd)
   );

   egaio_idx_file #(.DEPTH(SEQ_DEPTH), .WIDTH(DW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_we  (wr && hit.seq_idx),
      .dat_we  (wr && hit.seq_dat),
      .wdata   (wdata),
      .rd_data (seq_rd)
   );

   egaio_idx_file #(.DEPTH(GC_DEPTH), .WIDTH(DW)) u_gc (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_we  (wr && hit.gc_idx),
      .dat_we  (wr && hit.gc_dat),
      .wdata   (wdata),
      .rd_data (gc_rd)
   );

   egaio_unlock #(.CW(UNLOCK_CW), .THRESH(UNLOCK_THRESH), .WIDTH(DW)) u_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .probe  (rd && hit.unlock),
      .ext_wr (wr && hit.extmode),
      .wdata  (wdata),
      .ext_q  (ext_mode)
   );

   egaio_status #(.LAYOUT(LAYOUT_MONO)) u_stat_mono (
      .de (de_in), .lpen (lpen_in), .vsync (vsync_in), .stat (stat_mono)
   );

   egaio_status #(.LAYOUT(LAYOUT_COLOR)) u_stat_color (
      .de (de_in), .lpen (lpen_in), .vsync (vsync_in), .stat (stat_color)
   );

   always_comb begin
      rd_mux = '0;
      if (hit.crtc_dat)     rd_mux = crtc_rd;
      else if (hit.seq_dat) rd_mux = seq_rd;
      else if (hit.gc_dat)  rd_mux = gc_rd;
      else if (hit.status)  rd_mux = ctrl_q[0] ? stat_color : stat_mono;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pal_q  <= '0;
         rdata  <= '0;
      end else begin
         if (wr && hit.ctrl)   ctrl_q <= wdata;
         if (wr && hit.palext) pal_q  <= wdata;
         rdata <= rd ? rd_mux : '0;
      end
   end

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 10'h3C2) |=> (vram_en == $past(wdata[1]) && color_sel == $past(wdata[0]))); // R2
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (rdata == '0)); // R3
   AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr[9:4] == (color_sel ? HI_MONO : HI_COLOR)) |=> (rdata == '0)); // R12
   AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && hit.status) |=> (rdata[2] && rdata[6:4] == 3'b000)); // R9 R10
   AST_PAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 10'h3DD) |=> (pal_mode == $past(wdata))); // R11
endmodule

// File: tb/egaio_regs_test.sv
`timescale 1ns/1ps
module egaio_regs_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       rd = 1'b0, wr = 1'b0;
   logic [7:0] rdata;
   logic       de_in = 1'b1, vsync_in = 1'b0, lpen_in = 1'b0;
   logic       color_sel, vram_en;
   logic [7:0] ext_mode, pal_mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   egaio_regs uut (
      .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
      .rd (rd), .wr (wr), .rdata (rdata),
      .de_in (de_in), .vsync_in (vsync_in), .lpen_in (lpen_in),
      .color_sel (color_sel), .vram_en (vram_en),
      .ext_mode (ext_mode), .pal_mode (pal_mode)
   );

   // entry: {op[1:0], addr[9:0], wdata[7:0], expected[7:0], requirement[7:0]}
   localparam logic [1:0] OP_WR = 2'd0;
   localparam logic [1:0] OP_RD = 2'd1;
   localparam int NV = 30;
   localparam logic [35:0] VEC [NV] = '{
      {OP_WR, 10'h3B4, 8'h05, 8'h00, 8'd4},   // R4 mono index
      {OP_WR, 10'h3B5, 8'hA5, 8'h00, 8'd4},
      {OP_RD, 10'h3B5, 8'h00, 8'hA5, 8'd4},   // R4 readback
      {OP_RD, 10'h3D5, 8'h00, 8'h00, 8'd12},  // R12 inactive bank read
      {OP_WR, 10'h3D4, 8'h09, 8'h00, 8'd12},
      {OP_WR, 10'h3D5, 8'h11, 8'h00, 8'd12},
      {OP_RD, 10'h3B5, 8'h00, 8'hA5, 8'd12},  // R12 inactive writes ignored
      {OP_RD, 10'h3BA, 8'h00, 8'h85, 8'd9},   // R9 mono status
      {OP_RD, 10'h3DA, 8'h00, 8'h00, 8'd12},
      {OP_WR, 10'h3C4, 8'h0B, 8'h00, 8'd5},   // R5 index aliasing on [2:0]
      {OP_WR, 10'h3C5, 8'h3C, 8'h00, 8'd5},
      {OP_WR, 10'h3C4, 8'h03, 8'h00, 8'd5},
      {OP_RD, 10'h3C5, 8'h00, 8'h3C, 8'd5},
      {OP_WR, 10'h3C4, 8'h02, 8'h00, 8'd5},
      {OP_RD, 10'h3C5, 8'h00, 8'h00, 8'd5},
      {OP_WR, 10'h3CE, 8'h1F, 8'h00, 8'd6},   // R6 index aliasing on [3:0]
      {OP_WR, 10'h3CF, 8'hC3, 8'h00, 8'd6},
      {OP_WR, 10'h3CE, 8'h0F, 8'h00, 8'd6},
      {OP_RD, 10'h3CF, 8'h00, 8'hC3, 8'd6},
      {OP_WR, 10'h3DD, 8'h70, 8'h00, 8'd11},  // R11 in mono mode
      {OP_WR, 10'h3C2, 8'h01, 8'h00, 8'd2},   // R2 to color bank
      {OP_RD, 10'h3DA, 8'h00, 8'h8D, 8'd10},  // R10 color status
      {OP_RD, 10'h3BA, 8'h00, 8'h00, 8'd12},
      {OP_RD, 10'h3B5, 8'h00, 8'h00, 8'd12},
      {OP_WR, 10'h3D4, 8'h25, 8'h00, 8'd4},   // R4 index 5 via [4:0]
      {OP_RD, 10'h3D5, 8'h00, 8'hA5, 8'd4},
      {OP_WR, 10'h3D5, 8'h5E, 8'h00, 8'd4},
      {OP_RD, 10'h3D5, 8'h00, 8'h5E, 8'd4},
      {OP_WR, 10'h3C0, 8'hFF, 8'h00, 8'd12},
      {OP_RD, 10'h3C0, 8'h00, 8'h00, 8'd12}   // R12 unmapped
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic do_rd(input logic [9:0] a);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rdata", rdata, 8'h00);
      check("R1 ctrl", {6'b0, vram_en, color_sel}, 8'h00);
      check("R1 ext_mode", ext_mode, 8'h00);
      check("R1 pal_mode", pal_mode, 8'h00);
      do_rd(10'h3C5);
      check("R1 seq entry", rdata, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [35:0] v;
         v = VEC[i];
         if (v[35:34] == OP_WR) do_wr(v[33:24], v[23:16]);
         else begin
            do_rd(v[33:24]);
            check($sformatf("R%0d vec%0d", v[7:0], i), rdata, v[15:8]);
         end
      end

      // R11 palette byte loaded while in mono mode
      check("R11 pal_mode", pal_mode, 8'h70);
      check("R2 color_sel", {7'b0, color_sel}, 8'h01);

      // R2 video RAM enable
      do_wr(10'h3C2, 8'h03);
      check("R2 vram_en", {7'b0, vram_en}, 8'h01);

      // R3 rdata returns to zero the cycle after a read
      do_rd(10'h3D5);
      check("R3 read value", rdata, 8'h5E);
      @(negedge clk);
      check("R3 idle clear", rdata, 8'h00);

      // R10 status with other input levels
      de_in = 1'b0; lpen_in = 1'b1; vsync_in = 1'b1;
      do_rd(10'h3DA);
      check("R10 color status", rdata, 8'h86);

      // R8 locked writes are ignored
      do_wr(10'h3DB, 8'h5A);
      check("R8 locked at 0", ext_mode, 8'h00);
      do_rd(10'h3D8);
      do_wr(10'h3DB, 8'h5A);
      check("R8 locked at 1", ext_mode, 8'h00);
      // R7 a probe in the inactive bank does not count
      do_rd(10'h3B8);
      do_wr(10'h3DB, 8'h5A);
      check("R7 inactive probe", ext_mode, 8'h00);
      do_rd(10'h3D8);
      do_rd(10'h3D8);
      do_wr(10'h3DB, 8'h5A);
      check("R8 unlocked write", ext_mode, 8'h5A);
      do_wr(10'h3DB, 8'h33);
      check("R8 counter cleared", ext_mode, 8'h5A);
      // R7 saturation then exactly one accepted write
      for (int k = 0; k < 5; k++) do_rd(10'h3D8);
      do_wr(10'h3DB, 8'h33);
      check("R7 after saturation", ext_mode, 8'h33);
      do_rd(10'h3D8);
      do_wr(10'h3DB, 8'h77);
      check("R7 single probe after clear", ext_mode, 8'h33);

      // R9 mono status with other input levels
      do_wr(10'h3C2, 8'h00);
      check("R2 back to mono", {6'b0, vram_en, color_sel}, 8'h00);
      do_rd(10'h3BA);
      check("R9 mono status", rdata, 8'h06);

      // R12 extended byte in inactive bank ignored
      do_rd(10'h3D8); do_rd(10'h3D8);
      do_wr(10'h3DB, 8'hEE);
      check("R12 inactive ext write", ext_mode, 8'h33);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end
endmodule